// File: doc/BRIEF.md
# Video RAM Block-Copy DMA Controller

This block moves data from any address in the processor's 16-bit map into the 8 KiB video RAM window at 0x8000–0x9FFF. It always moves whole 16-byte units. Software loads five byte registers: source high and low, destination high and low, and a length/mode register. The write to the length/mode register is the trigger. Bit 7 of that byte picks the mode. When it is clear, the whole copy runs at once as a general transfer. When it is set, the copy is paced and moves one 16-byte unit for each rising edge of the horizontal-blank input.

Each byte takes a read cycle followed by a write cycle on a single byte-wide master port. The processor is held off through the stall output whenever the port is busy. The length/mode register also serves as a countdown status. When a unit finishes, the next source and destination addresses are written back into the address registers. This lets software continue a copy without reloading them.

Top module: `vram_copy_dma`

## Requirements
- R1: After reset the length/mode register reads 0xFF, and both `cpu_stall_o` and `mem_req_o` are low.
- R2: The source address used is {source high, source low} with its low 4 bits cleared.
- R3: A length/mode write is ignored when the aligned source lies in 0x8000–0x9FFF. Nothing starts, nothing is cancelled, and the length/mode register keeps its value. An aligned source of 0xA000 is accepted.
- R4: The destination address is 0x8000 | ({destination high, destination low} & 0x1FF0). It increments by one per byte and wraps from 0x9FFF to 0x8000. Every write strobe addresses 0x8000–0x9FFF.
- R5: A trigger byte v copies ((v & 0x7F) + 1) × 16 bytes, in ascending order.
- R6: Each byte uses two cycles. The first is a read strobe (`mem_req_o`=1, `mem_we_o`=0) at the source address. The second is a write strobe (`mem_we_o`=1) at the destination, whose data is the `mem_rdata_i` returned in the cycle after the read.
- R7: In general mode (trigger bit 7 = 0), `cpu_stall_o` rises on the clock edge that takes the trigger. It stays high for exactly 32 × ((v & 0x7F) + 1) cycles. At the end the length/mode register reads v | 0x80.
- R8: After each completed unit, the source registers hold the next source address and the destination registers hold the next destination address, with 0x80 included in the high byte.
- R9: In paced mode (trigger bit 7 = 1), the length/mode register reads v & 0x7F while the transfer is pending. Each rising edge of `hblank_i` copies exactly 16 bytes, with `cpu_stall_o` high for 32 cycles and low otherwise. The register then decrements once. The mode ends when it wraps to 0xFF, after which blanking edges copy nothing.
- R10: A length/mode write with bit 7 clear while a paced transfer is pending cancels it without starting a general transfer. The length/mode register then reads 0x80 | (remaining units − 1).
- R11: Register writes that arrive while `cpu_stall_o` is high have no effect.
- Register select codes on `reg_sel_i`: 0 source high, 1 source low, 2 destination high, 3 destination low, 4 length/mode. Codes 5–7 read 0xFF and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 3 | Register select for read and write |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_sel_i` (combinational) |
| hblank_i | input | 1 | Horizontal-blank level from video timing |
| mem_req_o | output | 1 | Master port strobe |
| mem_we_o | output | 1 | Master port write (1) or read (0) |
| mem_addr_o | output | 16 | Master port address |
| mem_wdata_o | output | 8 | Master port write data |
| mem_rdata_i | input | 8 | Read data, valid the cycle after a read strobe |
| cpu_stall_o | output | 1 | Processor hold while the port is busy |

## Verification
The cycle-by-cycle properties are checked on every cycle. Every write strobe lands in video RAM and directly follows a read strobe. Every stall interval starts from a general trigger or a rising blanking edge. Every stall interval carries a whole number of 16-byte units. Other behaviour can only be shown by the bench's scenarios. That covers the exact byte stream through the scoreboard, stall lengths, status and write-back values, rejection of video RAM sources, cancellation, and writes ignored under stall.

// File: rtl/vram_dma_pkg.sv
package vram_dma_pkg;
  typedef enum logic [2:0] {
    SEL_SRC_HI = 3'd0,
    SEL_SRC_LO = 3'd1,
    SEL_DST_HI = 3'd2,
    SEL_DST_LO = 3'd3,
    SEL_LEN    = 3'd4
  } reg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARMED,
    ST_COPY
  } seq_state_e;

  function automatic logic in_vram(input logic [15:0] a);
    return a[15:13] == 3'b100;
  endfunction
endpackage

// File: rtl/vram_dma_regs.sv
module vram_dma_regs
  import vram_dma_pkg::*;
#(
  parameter int UNIT_LG = 4,
  parameter int OFS_W   = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             addr_we_i,
  input  logic [2:0]       sel_i,
  input  logic [7:0]       wdata_i,
  input  logic             len_load_i,
  input  logic             cancel_i,
  input  logic             unit_done_i,
  input  logic             unit_last_i,
  input  logic             paced_i,
  input  logic [15:0]      next_src_i,
  input  logic [OFS_W-1:0] next_dst_i,
  output logic [7:0]       rdata_o,
  output logic [15:0]      src_base_o,
  output logic [OFS_W-1:0] dst_base_o
);
  localparam logic [15:0] ALIGN_MASK = ~((16'd1 << UNIT_LG) - 16'd1);
  localparam int          HI_OFS_W   = OFS_W - 8;

  logic [7:0] src_hi_q, src_lo_q, dst_hi_q, dst_lo_q, len_q;
  logic [15:0] dst_full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_hi_q <= '0;
      src_lo_q <= '0;
      dst_hi_q <= '0;
      dst_lo_q <= '0;
      len_q    <= 8'hFF;
    end else begin
      if (addr_we_i) begin
        unique case (reg_sel_e'(sel_i))
          SEL_SRC_HI: src_hi_q <= wdata_i;
          SEL_SRC_LO: src_lo_q <= wdata_i;
          SEL_DST_HI: dst_hi_q <= wdata_i;
          SEL_DST_LO: dst_lo_q <= wdata_i;
          default: ;
        endcase
      end
      if (len_load_i) len_q <= {1'b0, wdata_i[6:0]};
      if (cancel_i)   len_q <= {1'b1, len_q[6:0]};
      if (unit_done_i) begin
        src_hi_q <= next_src_i[15:8];
        src_lo_q <= next_src_i[7:0];
        dst_hi_q <= {{(8-HI_OFS_W){1'b0}}, next_dst_i[OFS_W-1:8]} | 8'h80;
        dst_lo_q <= next_dst_i[7:0];
        if (paced_i)          len_q    <= len_q - 8'd1;
        else if (unit_last_i) len_q[7] <= 1'b1;
      end
    end
  end

  assign dst_full   = {dst_hi_q, dst_lo_q} & ALIGN_MASK;
  assign src_base_o = {src_hi_q, src_lo_q} & ALIGN_MASK;
  assign dst_base_o = dst_full[OFS_W-1:0];

  always_comb begin
    unique case (reg_sel_e'(sel_i))
      SEL_SRC_HI: rdata_o = src_hi_q;
      SEL_SRC_LO: rdata_o = src_lo_q;
      SEL_DST_HI: rdata_o = dst_hi_q;
      SEL_DST_LO: rdata_o = dst_lo_q;
      SEL_LEN:    rdata_o = len_q;
      default:    rdata_o = 8'hFF;
    endcase
  end
endmodule

// File: rtl/vram_dma_seq.sv
module vram_dma_seq
  import vram_dma_pkg::*;
#(
  parameter int UNIT_LG = 4,
  parameter int CNT_W   = 7,
  parameter int OFS_W   = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cancel_i,
  input  logic             paced_i,
  input  logic [CNT_W-1:0] units_i,
  input  logic [15:0]      src_i,
  input  logic [OFS_W-1:0] dst_i,
  input  logic             hblank_i,
  input  logic [7:0]       mem_rdata_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [15:0]      mem_addr_o,
  output logic [7:0]       mem_wdata_o,
  output logic             stall_o,
  output logic             paced_active_o,
  output logic             unit_done_o,
  output logic             unit_last_o,
  output logic             paced_o,
  output logic [15:0]      next_src_o,
  output logic [OFS_W-1:0] next_dst_o
);
  localparam int WIN_W = 16 - OFS_W;
  localparam logic [WIN_W-1:0] WIN_TAG = {1'b1, {(WIN_W-1){1'b0}}};

  seq_state_e         state_q;
  logic [15:0]        src_q;
  logic [OFS_W-1:0]   dst_q;
  logic [UNIT_LG-1:0] byte_q;
  logic [CNT_W-1:0]   units_q;
  logic               phase_q, paced_q, hb_q, hb_rise;

  assign hb_rise = hblank_i && !hb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      byte_q  <= '0;
      units_q <= '0;
      phase_q <= 1'b0;
      paced_q <= 1'b0;
      hb_q    <= 1'b0;
    end else begin
      hb_q <= hblank_i;
      unique case (state_q)
        ST_IDLE, ST_ARMED: begin
          if (cancel_i) begin
            state_q <= ST_IDLE;
          end else if (start_i) begin
            src_q   <= src_i;
            dst_q   <= dst_i;
            units_q <= units_i;
            byte_q  <= '0;
            phase_q <= 1'b0;
            paced_q <= paced_i;
            state_q <= paced_i ? ST_ARMED : ST_COPY;
          end else if (state_q == ST_ARMED && hb_rise) begin
            state_q <= ST_COPY;
          end
        end
        ST_COPY: begin
          phase_q <= ~phase_q;
          if (phase_q) begin
            src_q  <= src_q + 16'd1;
            dst_q  <= dst_q + 1'b1;
            byte_q <= byte_q + 1'b1;
            if (&byte_q) begin
              if (units_q == '0) begin
                state_q <= ST_IDLE;
              end else begin
                units_q <= units_q - 1'b1;
                state_q <= paced_q ? ST_ARMED : ST_COPY;
              end
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign stall_o        = state_q == ST_COPY;
  assign mem_req_o      = stall_o;
  assign mem_we_o       = stall_o && phase_q;
  assign mem_addr_o     = phase_q ? {WIN_TAG, dst_q} : src_q;
  assign mem_wdata_o    = mem_rdata_i;
  assign paced_active_o = paced_q && state_q != ST_IDLE;
  assign unit_done_o    = stall_o && phase_q && (&byte_q);
  assign unit_last_o    = units_q == '0;
  assign paced_o        = paced_q;
  assign next_src_o     = src_q + 16'd1;
  assign next_dst_o     = dst_q + 1'b1;
endmodule

// File: rtl/vram_copy_dma.sv
module vram_copy_dma
  import vram_dma_pkg::*;
#(
  parameter int UNIT_LG = 4,
  parameter int CNT_W   = 7
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [2:0]  reg_sel_i,
  input  logic [7:0]  reg_wdata_i,
  output logic [7:0]  reg_rdata_o,
  input  logic        hblank_i,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic [15:0] mem_addr_o,
  output logic [7:0]  mem_wdata_o,
  input  logic [7:0]  mem_rdata_i,
  output logic        cpu_stall_o
);
  localparam int OFS_W = 13;

  logic             wr_ok, len_wr, src_bad, start, cancel, gen_launch;
  logic             paced_active, unit_done, unit_last, paced;
  logic [15:0]      src_base, next_src;
  logic [OFS_W-1:0] dst_base, next_dst;

  assign wr_ok      = reg_we_i && !cpu_stall_o;
  assign len_wr     = wr_ok && reg_sel_i == SEL_LEN;
  assign src_bad    = in_vram(src_base);
  assign start      = len_wr && !src_bad && (reg_wdata_i[7] || !paced_active);
  assign cancel     = len_wr && !src_bad && !reg_wdata_i[7] && paced_active;
  assign gen_launch = start && !reg_wdata_i[7];

  vram_dma_regs #(.UNIT_LG(UNIT_LG), .OFS_W(OFS_W)) i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_we_i   (wr_ok && reg_sel_i < SEL_LEN),
    .sel_i       (reg_sel_i),
    .wdata_i     (reg_wdata_i),
    .len_load_i  (start),
    .cancel_i    (cancel),
    .unit_done_i (unit_done),
    .unit_last_i (unit_last),
    .paced_i     (paced),
    .next_src_i  (next_src),
    .next_dst_i  (next_dst),
    .rdata_o     (reg_rdata_o),
    .src_base_o  (src_base),
    .dst_base_o  (dst_base)
  );

  vram_dma_seq #(.UNIT_LG(UNIT_LG), .CNT_W(CNT_W), .OFS_W(OFS_W)) i_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .start_i        (start),
    .cancel_i       (cancel),
    .paced_i        (reg_wdata_i[7]),
    .units_i        (reg_wdata_i[CNT_W-1:0]),
    .src_i          (src_base),
    .dst_i          (dst_base),
    .hblank_i       (hblank_i),
    .mem_rdata_i    (mem_rdata_i),
    .mem_req_o      (mem_req_o),
    .mem_we_o       (mem_we_o),
    .mem_addr_o     (mem_addr_o),
    .mem_wdata_o    (mem_wdata_o),
    .stall_o        (cpu_stall_o),
    .paced_active_o (paced_active),
    .unit_done_o    (unit_done),
    .unit_last_o    (unit_last),
    .paced_o        (paced),
    .next_src_o     (next_src),
    .next_dst_o     (next_dst)
  );
endmodule

// File: rtl/vram_dma_checker.sv
module vram_dma_checker #(
  parameter int UNIT_LG = 4,
  parameter int WCNT_W  = 12
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        mem_req_i,
  input logic        mem_we_i,
  input logic [15:0] mem_addr_i,
  input logic        stall_i,
  input logic        hblank_i,
  input logic        gen_launch_i
);
  logic [WCNT_W-1:0] wr_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  wr_cnt_q <= '0;
    else if (!stall_i)            wr_cnt_q <= '0;
    else if (mem_req_i && mem_we_i) wr_cnt_q <= wr_cnt_q + 1'b1;
  end

  p_dst_window_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i && mem_we_i |-> mem_addr_i[15:13] == 3'b100);

  p_rd_then_wr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i && !mem_we_i |=> mem_req_i && mem_we_i);

  p_wr_after_rd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_i && mem_we_i |-> $past(mem_req_i && !mem_we_i));

  p_stall_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stall_i) |-> $past(gen_launch_i) || ($past(hblank_i) && !$past(hblank_i, 2)));

  p_whole_units_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stall_i) |-> wr_cnt_q[UNIT_LG-1:0] == '0 && wr_cnt_q != '0);
endmodule

bind vram_copy_dma vram_dma_checker #(.UNIT_LG(UNIT_LG)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mem_req_i    (mem_req_o),
  .mem_we_i     (mem_we_o),
  .mem_addr_i   (mem_addr_o),
  .stall_i      (cpu_stall_o),
  .hblank_i     (hblank_i),
  .gen_launch_i (gen_launch)
);

// File: tb/test_vram_copy_dma.sv
module test_vram_copy_dma;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic        hblank = 1'b0;
  logic        mem_req, mem_we, cpu_stall;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 8'h00;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [23:0] sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  vram_copy_dma i_vram_copy_dma (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .hblank_i(hblank),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .cpu_stall_o(cpu_stall)
  );

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  // source memory model: data the cycle after a read strobe
  always @(posedge clk) if (mem_req && !mem_we) mem_rdata <= pat(mem_addr);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin : mon
    logic [23:0] e;
    if (rst_n && mem_req && mem_we) begin
      if (sb_q.size() == 0) chk(1'b0, "R6 unexpected write", {8'h0, mem_addr, mem_wdata}, 32'h0);
      else begin
        e = sb_q.pop_front();
        chk({mem_addr, mem_wdata} == e, "R6/R4 write stream", {8'h0, mem_addr, mem_wdata}, {8'h0, e});
      end
    end
  end

  task automatic push_xfer(input logic [15:0] src, input logic [12:0] dst, input int n);
    for (int k = 0; k < n; k++) begin
      logic [12:0] d;
      logic [15:0] s;
      d = dst + 13'(k);
      s = src + 16'(k);
      sb_q.push_back({3'b100, d, pat(s)});
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, input logic [7:0] exp, input string tag);
    @(negedge clk);
    reg_sel = sel;
    #1;
    chk(reg_rdata == exp, tag, {24'h0, reg_rdata}, {24'h0, exp});
  endtask

  task automatic setup(input logic [15:0] src, input logic [15:0] dst);
    wr(3'd0, src[15:8]); wr(3'd1, src[7:0]);
    wr(3'd2, dst[15:8]); wr(3'd3, dst[7:0]);
  endtask

  task automatic stall_len(output int n);
    n = 0;
    while (cpu_stall) begin n++; @(negedge clk); end
  endtask

  task automatic hb_burst(output int n);
    @(negedge clk); hblank = 1'b1;
    @(negedge clk); hblank = 1'b0;
    stall_len(n);
  endtask

  task automatic quiet(input int cyc, input string tag);
    bit seen;
    seen = 1'b0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (cpu_stall || mem_req) seen = 1'b1;
    end
    chk(!seen, tag, {31'h0, seen}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(!cpu_stall && !mem_req, "R1 stall/req low", {30'h0, cpu_stall, mem_req}, 32'h0);
    rd(3'd4, 8'hFF, "R1 length reset");
    rd(3'd6, 8'hFF, "R1 unused select");

    // R2/R4/R5/R7 general: src 0x1237 -> 0x1230, dst 0xF34F -> 0x9340, 32 bytes
    setup(16'h1237, 16'hF34F);
    push_xfer(16'h1230, 13'h1340, 32);
    wr(3'd4, 8'h01);
    stall_len(n);
    chk(n == 64, "R7 general stall cycles", n, 64);
    chk(sb_q.size() == 0, "R5 byte count", sb_q.size(), 0);
    rd(3'd4, 8'h81, "R7 length done");
    rd(3'd0, 8'h12, "R8 src hi");
    rd(3'd1, 8'h50, "R8 src lo");
    rd(3'd2, 8'h93, "R8 dst hi");
    rd(3'd3, 8'h60, "R8 dst lo");

    // R4 destination wrap, R3 source 0xA000 accepted
    setup(16'hA00F, 16'h1FF0);
    push_xfer(16'hA000, 13'h1FF0, 32);
    wr(3'd4, 8'h01);
    stall_len(n);
    chk(n == 64, "R3 A000 accepted", n, 64);
    chk(sb_q.size() == 0, "R4 wrap stream done", sb_q.size(), 0);
    rd(3'd2, 8'h80, "R4 dst hi after wrap");
    rd(3'd3, 8'h10, "R4 dst lo after wrap");

    // R3 source in video RAM rejected
    setup(16'h9FFF, 16'h0000);
    wr(3'd4, 8'h00);
    quiet(40, "R3 no transfer from vram");
    rd(3'd4, 8'h81, "R3 length unchanged");

    // R9 paced: 3 units
    setup(16'h2000, 16'h0100);
    push_xfer(16'h2000, 13'h0100, 48);
    wr(3'd4, 8'h82);
    rd(3'd4, 8'h02, "R9 pending length");
    quiet(20, "R9 no copy without blank");
    hb_burst(n);
    chk(n == 32, "R9 burst 1 stall", n, 32);
    rd(3'd4, 8'h01, "R9 length after unit 1");
    rd(3'd1, 8'h10, "R8 paced src lo");
    rd(3'd3, 8'h10, "R8 paced dst lo");
    hb_burst(n);
    chk(n == 32, "R9 burst 2 stall", n, 32);
    rd(3'd4, 8'h00, "R9 length after unit 2");
    hb_burst(n);
    chk(n == 32, "R9 burst 3 stall", n, 32);
    rd(3'd4, 8'hFF, "R9 wrap ends mode");
    hb_burst(n);
    chk(n == 0, "R9 no copy after end", n, 0);
    chk(sb_q.size() == 0, "R9 paced stream done", sb_q.size(), 0);

    // R10 cancel
    setup(16'h5000, 16'h0200);
    push_xfer(16'h5000, 13'h0200, 16);
    wr(3'd4, 8'h85);
    hb_burst(n);
    chk(n == 32, "R10 first unit", n, 32);
    rd(3'd4, 8'h04, "R10 length before cancel");
    wr(3'd4, 8'h00);
    quiet(10, "R10 cancel starts nothing");
    rd(3'd4, 8'h84, "R10 length after cancel");
    hb_burst(n);
    chk(n == 0, "R10 no copy after cancel", n, 0);

    // R11 writes under stall ignored
    setup(16'h3000, 16'h0400);
    push_xfer(16'h3000, 13'h0400, 64);
    wr(3'd4, 8'h03);
    repeat (4) @(negedge clk);
    wr(3'd2, 8'h00);
    wr(3'd4, 8'h00);
    stall_len(n);
    chk(sb_q.size() == 0, "R11 stream intact", sb_q.size(), 0);
    rd(3'd4, 8'h83, "R11 length");
    rd(3'd2, 8'h84, "R11 dst hi");
    rd(3'd3, 8'h40, "R11 dst lo");
    rd(3'd1, 8'h40, "R11 src lo");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule